// File: doc/BRIEF.md
# Pulse Edge Timestamp Capture Unit

This block timestamps the rising edges of an external once-per-second style pulse against a free-running time base, without requiring the edge to be latched by the bus side at the moment it happens. A prescaler divides the block clock by `DIV`. Two `CNT_W`-bit counters advance on that shared tick:

- **Time base:** runs freely and wraps modulo 2^`CNT_W`.
- **Age counter:** restarts from zero whenever a synchronized rising edge of the input is seen. Its value therefore tells how many ticks ago the edge occurred.

A poller issues a one-cycle snapshot strobe. In that one clock the block records three things together: the synchronized pin level, the time-base count and the age counter. If the recorded pin level is high and the previous snapshot saw it low, the block forms a corrected stamp equal to (time base − age) modulo 2^`CNT_W`. It then raises a valid flag, which a read strobe clears. A snapshot that finds the pin unchanged, or changed to low, produces no stamp.

The pin level that the snapshot records is the delayed copy that matches the age counter. As a result, an edge that is still passing through the synchronizer can never be paired with an age count that has not yet been restarted.

An optional echo output follows the detected transitions and has a selectable polarity. It is meant for visual indication only.

Top module: `pulse_stamp_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `tbase_o`, `stamp_o`, `stamp_valid_o` and `snap_pin_o` are all zero. `echo_o` equals `echo_inv_i`.
- R2: After the N-th rising clock edge following reset release, `tbase_o` equals floor(N/DIV) modulo 2^CNT_W. The time base advances by exactly one every DIV clocks and wraps from all ones to zero.
- R3: Let edge a be the first rising clock edge at which `pulse_in` is sampled high. A later capture reports a `stamp_o` equal to the time-base count present after edge a+2, that is floor((a+2)/DIV) modulo 2^CNT_W. This value is independent of how long after the edge the snapshot is taken, including across a time-base wrap.
- R4: A capture happens only when `snap_i` samples a recorded pin level of high and the previous snapshot recorded low. A snapshot that records an unchanged level, or a change to low, leaves `stamp_o` and `stamp_valid_o` unchanged.
- R5: A snapshot taken at clock edge E records, on `snap_pin_o`, the level of `pulse_in` sampled at edge E-3. A snapshot at edge a+2 therefore still reports low and captures nothing.
- R6: `stamp_valid_o` is set by a capture and cleared by `cap_read_i`. When both happen in the same cycle, the capture wins and the flag ends up set.
- R7: The echo level goes high on a captured low-to-high transition and low on a detected high-to-low transition. `echo_o` is that level XOR `echo_inv_i`.
- R8: Each new rising edge restarts the age counter. A second pulse yields a stamp computed from its own edge per R3, unaffected by earlier pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Asynchronous external pulse |
| snap_i | input | 1 | One-cycle snapshot strobe from the poller |
| cap_read_i | input | 1 | Clears the stamp valid flag |
| echo_inv_i | input | 1 | Inverts the echo output polarity |
| tbase_o | output | CNT_W | Live free-running time-base count |
| stamp_o | output | CNT_W | Last corrected edge timestamp |
| stamp_valid_o | output | 1 | A stamp has been captured and not yet read |
| snap_pin_o | output | 1 | Pin level recorded by the last snapshot |
| echo_o | output | 1 | Echo of detected pulse transitions |

## Verification
The bench raises the pulse at random offsets relative to the prescaler phase and polls a random number of ticks later. A design that latched the raw count, or subtracted an age counter restarted one cycle off, would then report a stamp that drifts with the poll delay or misses by one tick. A snapshot is deliberately placed in the cycle where the edge has crossed the synchronizer but the age counter has not restarted. A design that recorded the undelayed pin level would capture there, with a stale age. Further cases target a pulse straddling the time-base wrap, unchanged and falling polls that must not disturb the stamp, and a read coinciding with a capture. Each would expose, respectively, non-modular arithmetic, spurious captures, and the wrong priority on the valid flag.

// File: rtl/ps_pkg.sv
package ps_pkg;

    // three-stage input chain: two metastability stages plus one history stage
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    function automatic logic sync_rise(input sync_t s);
        return s.s2 & ~s.s3;
    endfunction

endpackage

// File: rtl/ps_prescale.sv
module ps_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = (cnt_q == LAST);
        if (tick_o) cnt_d = '0;
        else        cnt_d = cnt_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (DIV > 1) begin : g_gap
            // R2: ticks are isolated single cycles
            a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/ps_counter.sv
module ps_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (clr_i)     q_d = '0;
        else if (en_i) q_d = q_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q_o = q_q;

endmodule

// File: rtl/ps_sync_edge.sv
module ps_sync_edge
    import ps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic held_o,
    output logic rise_o
);
    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        rise_o  = sync_rise(st_q);
        held_o  = st_q.s3;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: the held level trails the detected rise by exactly one cycle
    a_r5_held_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> held_o);

endmodule

// File: rtl/pulse_stamp_top.sv
module pulse_stamp_top #(
    parameter int CNT_W   = 16,
    parameter int DIV     = 4,
    parameter bit ECHO_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             snap_i,
    input  logic             cap_read_i,
    input  logic             echo_inv_i,
    output logic [CNT_W-1:0] tbase_o,
    output logic [CNT_W-1:0] stamp_o,
    output logic             stamp_valid_o,
    output logic             snap_pin_o,
    output logic             echo_o
);
    typedef struct packed {
        logic [CNT_W-1:0] stamp;
        logic             valid;
        logic             pin;
        logic             echo_lvl;
    } cap_t;

    logic             tick;
    logic             held;
    logic             rise;
    logic [CNT_W-1:0] tb_cnt;
    logic [CNT_W-1:0] age_cnt;
    logic             capture;
    logic             drop;
    cap_t             st_d, st_q;

    ps_prescale #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    ps_sync_edge u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pulse_in),
        .held_o (held),
        .rise_o (rise)
    );

    ps_counter #(.W(CNT_W)) u_tbase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (1'b0),
        .en_i  (tick),
        .q_o   (tb_cnt)
    );

    ps_counter #(.W(CNT_W)) u_age (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (rise),
        .en_i  (tick),
        .q_o   (age_cnt)
    );

    // The snapshot records the delayed level (held), which is the level
    // consistent with the age counter already having been restarted.
    always_comb begin
        st_d    = st_q;
        capture = snap_i & held & ~st_q.pin;
        drop    = snap_i & ~held & st_q.pin;
        if (snap_i) st_d.pin = held;
        if (capture) begin
            st_d.stamp    = tb_cnt - age_cnt;
            st_d.echo_lvl = 1'b1;
        end
        if (drop) st_d.echo_lvl = 1'b0;
        if (capture)         st_d.valid = 1'b1;
        else if (cap_read_i) st_d.valid = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tbase_o       = tb_cnt;
    assign stamp_o       = st_q.stamp;
    assign stamp_valid_o = st_q.valid;
    assign snap_pin_o    = st_q.pin;

    generate
        if (ECHO_EN) begin : g_echo
            assign echo_o = st_q.echo_lvl ^ echo_inv_i;
        end else begin : g_no_echo
            assign echo_o = 1'b0;
        end
    endgenerate

    // R2: time base advances only on prescaler ticks
    a_r2_tb_advance: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> tbase_o == $past(tbase_o) + CNT_W'(1));
    a_r2_tb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tbase_o));
    // R8: every detected rise restarts the age counter
    a_r8_age_restart: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> age_cnt == '0);
    // R4: without a low-to-high snapshot the stamp does not move
    a_r4_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(snap_i && held && !snap_pin_o) |=> $stable(stamp_o));
    // R6: a capture always leaves the flag set; a lone read clears it
    a_r6_cap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_i && held && !snap_pin_o) |=> stamp_valid_o);
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_read_i && !snap_i) |=> !stamp_valid_o);
    // R7: a falling snapshot drives the echo level low
    a_r7_echo_low: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_i && !held && snap_pin_o) |=> !st_q.echo_lvl);

endmodule

// File: tb/sim_pulse_stamp_top.sv
module sim_pulse_stamp_top;
    localparam int W   = 12;
    localparam int DIV = 4;
    localparam int MOD = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pulse_in = 1'b0;
    logic         snap_i = 1'b0;
    logic         cap_read_i = 1'b0;
    logic         echo_inv_i = 1'b0;
    logic [W-1:0] tbase_o;
    logic [W-1:0] stamp_o;
    logic         stamp_valid_o;
    logic         snap_pin_o;
    logic         echo_o;

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    int exp_q[$];
    logic vprev = 1'b0;

    pulse_stamp_top #(.CNT_W(W), .DIV(DIV), .ECHO_EN(1'b1)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .pulse_in      (pulse_in),
        .snap_i        (snap_i),
        .cap_read_i    (cap_read_i),
        .echo_inv_i    (echo_inv_i),
        .tbase_o       (tbase_o),
        .stamp_o       (stamp_o),
        .stamp_valid_o (stamp_valid_o),
        .snap_pin_o    (snap_pin_o),
        .echo_o        (echo_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) n = n + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops an expected stamp each time the valid flag rises
    always @(negedge clk) begin
        if (rst_n && stamp_valid_o && !vprev) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R3 actual=%0d expected=none", stamp_o);
            end else begin
                int e;
                e = exp_q.pop_front();
                check("R3 stamp", int'(stamp_o), e);
            end
        end
        vprev = stamp_valid_o;
    end

    task automatic raise(input logic lvl, output int a);
        @(posedge clk);
        #($urandom_range(1, 3));
        pulse_in = lvl;
        a = n + 1;
    endtask

    task automatic snap_at(input int e, input logic rd);
        @(negedge clk);
        while (n < e - 1) @(negedge clk);
        snap_i = 1'b1;
        cap_read_i = rd;
        @(posedge clk);
        #1;
        snap_i = 1'b0;
        cap_read_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk);
        cap_read_i = 1'b1;
        @(posedge clk);
        #1;
        cap_read_i = 1'b0;
        @(negedge clk);
    endtask

    function automatic int stamp_for(input int a);
        return ((a + 2) / DIV) % MOD;
    endfunction

    // one full pulse: rise, capture after a random delay, read, fall
    task automatic pulse_cycle(input int gap, input string tag);
        int a;
        int f;
        raise(1'b1, a);
        exp_q.push_back(stamp_for(a));
        snap_at(a + 3 + gap, 1'b0);
        check({tag, " pin high"}, int'(snap_pin_o), 1);
        check({tag, " valid"}, int'(stamp_valid_o), 1);
        do_read();
        raise(1'b0, f);
        snap_at(f + 3, 1'b0);
        check({tag, " pin low"}, int'(snap_pin_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int a;
        int f;
        logic [W-1:0] hold;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 tbase", int'(tbase_o), 0);
        check("R1 valid", int'(stamp_valid_o), 0);
        check("R1 stamp", int'(stamp_o), 0);
        check("R1 pin", int'(snap_pin_o), 0);
        check("R1 echo", int'(echo_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tbase after release", int'(tbase_o), 0);

        // R2 time base rate
        repeat (13) @(negedge clk);
        check("R2 tbase", int'(tbase_o), (n / DIV) % MOD);
        repeat (7) @(negedge clk);
        check("R2 tbase", int'(tbase_o), (n / DIV) % MOD);

        // R5 snapshot during synchronizer transit sees low, no capture
        raise(1'b1, a);
        snap_at(a + 2, 1'b0);
        check("R5 pin still low", int'(snap_pin_o), 0);
        check("R5 no capture", int'(stamp_valid_o), 0);
        exp_q.push_back(stamp_for(a));
        snap_at(a + 3 + $urandom_range(0, 20), 1'b0);
        check("R5 pin high", int'(snap_pin_o), 1);
        check("R7 echo high", int'(echo_o), 1);
        check("R6 valid set", int'(stamp_valid_o), 1);
        do_read();
        check("R6 read clears", int'(stamp_valid_o), 0);
        hold = stamp_o;

        // R4 unchanged-high poll: nothing captured
        snap_at(n + 5, 1'b0);
        check("R4 unchanged valid", int'(stamp_valid_o), 0);
        check("R4 unchanged stamp", int'(stamp_o), int'(hold));

        // R4 / R7 falling poll
        raise(1'b0, f);
        snap_at(f + 3, 1'b0);
        check("R4 fall valid", int'(stamp_valid_o), 0);
        check("R4 fall stamp", int'(stamp_o), int'(hold));
        check("R7 echo low", int'(echo_o), 0);
        echo_inv_i = 1'b1;
        #1;
        check("R7 echo inverted", int'(echo_o), 1);
        echo_inv_i = 1'b0;

        // R8 repeated pulses at random prescaler phases
        for (int i = 0; i < 8; i++) begin
            repeat ($urandom_range(0, 40)) @(posedge clk);
            pulse_cycle($urandom_range(0, 60), "R8");
        end

        // R6 capture and read in the same cycle: capture wins
        raise(1'b1, a);
        exp_q.push_back(stamp_for(a));
        snap_at(a + 4, 1'b1);
        check("R6 capture beats read", int'(stamp_valid_o), 1);
        do_read();
        raise(1'b0, f);
        snap_at(f + 3, 1'b0);

        // R3 pulse straddling the time-base wrap
        while (n < MOD * DIV - 6) @(posedge clk);
        raise(1'b1, a);
        exp_q.push_back(stamp_for(a));
        snap_at(a + 30, 1'b0);
        check("R3 wrap valid", int'(stamp_valid_o), 1);
        check("R2 tbase after wrap", int'(tbase_o), (n / DIV) % MOD);
        do_read();

        repeat (4) @(negedge clk);
        check("R3 queue drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule